// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns bytes into asynchronous serial frames. A byte written into a one-entry holding register waits there. Once the clear-to-send input allows it and the next oversampling tick arrives, the byte moves into the shift stage and goes out on the serial line. The frame is one start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then stop bits.

A 7-bit line-control input sets the frame format: character length, stop-bit count, parity mode and a line-break override. A 16-bit divisor sets the bit timing. It divides the input clock into a 16x oversampling tick, and each bit lasts 16 ticks. With the classic 1.8432 MHz clock, a divisor of 115200 divided by the baud rate gives that baud rate. The two status outputs tell the host when it may write the next byte and when the line has fully drained.

Top module: `serial_frame_tx`

## Requirements
- R1: The line idles at 1. A frame is one start bit at 0, then the data bits with bit 0 first. The character length comes from `lcr_i[1:0]`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the chosen length are not sent.
- R2: When `lcr_i[3]` is 1, one parity bit follows the data. With `lcr_i[5]`=0, the parity bit makes the count of ones over the data and parity bits even when `lcr_i[4]`=1, and odd when `lcr_i[4]`=0. When `lcr_i[3]` is 0, no parity bit is sent.
- R3: When `lcr_i[3]` and `lcr_i[5]` are both 1, the parity bit is a constant: 0 when `lcr_i[4]`=1 and 1 when `lcr_i[4]`=0.
- R4: The stop level is 1. It lasts 1 bit when `lcr_i[2]`=0. When `lcr_i[2]`=1 it lasts 2 bits, except for 5-bit characters, where it lasts 1.5 bits.
- R5: While `lcr_i[6]` is 1, `txd_o` is 0, whatever the transmitter state.
- R6: A nonzero `div_i` makes every bit last 16×`div_i` clock cycles. A `div_i` of 0 stops the tick: no frame starts and the line stays idle.
- R7: A held byte does not start a frame while `cts_i` is 0. It starts after `cts_i` returns to 1.
- R8: `thre_o` goes to 0 on the cycle after a write. It returns to 1 on the cycle after the held byte moves into the shift stage.
- R9: `temt_o` is 1 only when the holding register is empty and no frame is being shifted out.
- R10: After reset, `txd_o`, `thre_o` and `temt_o` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| lcr_i | input | 7 | Line control: [1:0] length, [2] stop, [3] parity enable, [4] even, [5] sticky, [6] break |
| div_i | input | 16 | Oversampling divisor; 0 stops the tick |
| cts_i | input | 1 | Clear to send; gates the start of a frame |
| txd_o | output | 1 | Serial output line |
| thre_o | output | 1 | Holding register empty |
| temt_o | output | 1 | Holding register and shift stage both empty |

## Verification
The bench builds the block with its default 16x oversampling and 16-bit divisor. It sweeps all 64 format settings, from length through sticky parity, with two data patterns each. A divisor of 1 makes a bit exactly 16 cycles, so the whole sweep fits in a short run and the end of the stop time can be checked to within two cycles. Extra frames at a divisor of 3 confirm that bit time scales with the divisor. Directed cases cover a zero divisor, clear-to-send held low and the break override.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop2;
    logic [1:0] len;
  } line_ctl_t;
endpackage

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i - 1'b1) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R6
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && div_i > 1 && $stable(div_i) |=> !tick_o);
  // R6
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_i == '0 && $past(div_i) == '0 |=> !tick_o);
endmodule

// File: rtl/tx_frame.sv
module tx_frame
  import tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  line_ctl_t  ctl_i,
  input  logic       cts_i,
  output logic       txd_o,
  output logic       thre_o,
  output logic       temt_o
);
  localparam int CNT_W = $clog2(2 * OSR);
  localparam logic [CNT_W-1:0] LAST_1   = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] LAST_1P5 = CNT_W'(OSR + OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_2   = CNT_W'(2 * OSR - 1);

  tx_state_e        state_q;
  line_ctl_t        cfg_q;
  logic [7:0]       hold_q, shift_q;
  logic             hold_full_q, par_q;
  logic [2:0]       bit_idx_q;
  logic [CNT_W-1:0] tcnt_q;
  logic             load, cell_end;
  logic [CNT_W-1:0] last_cnt;
  logic [7:0]       masked;
  logic             par_calc;

  assign load = (state_q == ST_IDLE) && hold_full_q && cts_i && tick_i;

  always_comb begin
    unique case (ctl_i.len)
      2'd0:    masked = {3'b0, hold_q[4:0]};
      2'd1:    masked = {2'b0, hold_q[5:0]};
      2'd2:    masked = {1'b0, hold_q[6:0]};
      default: masked = hold_q;
    endcase
    if (ctl_i.stick) par_calc = ~ctl_i.even;
    else             par_calc = ctl_i.even ? ^masked : ~^masked;
  end

  always_comb begin
    last_cnt = LAST_1;
    if (state_q == ST_STOP && cfg_q.stop2)
      last_cnt = (cfg_q.len == 2'd0) ? LAST_1P5 : LAST_2;
  end

  assign cell_end = tick_i && (tcnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cfg_q       <= '0;
      hold_q      <= '0;
      shift_q     <= '0;
      hold_full_q <= 1'b0;
      par_q       <= 1'b0;
      bit_idx_q   <= '0;
      tcnt_q      <= '0;
    end else begin
      if (load) begin
        state_q     <= ST_START;
        cfg_q       <= ctl_i;
        shift_q     <= masked;
        par_q       <= par_calc;
        hold_full_q <= 1'b0;
        tcnt_q      <= '0;
        bit_idx_q   <= '0;
      end else if (state_q != ST_IDLE && tick_i) begin
        tcnt_q <= cell_end ? '0 : tcnt_q + 1'b1;
        if (cell_end) begin
          unique case (state_q)
            ST_START: state_q <= ST_DATA;
            ST_DATA: begin
              shift_q <= shift_q >> 1;
              if (bit_idx_q == {1'b1, cfg_q.len})
                state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
              bit_idx_q <= bit_idx_q + 1'b1;
            end
            ST_PAR:  state_q <= ST_STOP;
            default: state_q <= ST_IDLE;
          endcase
        end
      end
      if (wr_en_i) begin
        hold_q      <= wr_data_i;
        hold_full_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shift_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
    if (ctl_i.brk) txd_o = 1'b0;
  end

  assign thre_o = !hold_full_q;
  assign temt_o = !hold_full_q && (state_q == ST_IDLE);

  // R8
  thre_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thre_o) |-> $past(load));
  // R8
  thre_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !thre_o);
  // R7
  cts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && !cts_i |=> state_q == ST_IDLE);
  // R6
  hold_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE && !tick_i |=> $stable(state_q) && $stable(shift_q));
  // R1
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && !ctl_i.brk |=> !txd_o || ctl_i.brk);
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [6:0]       lcr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cts_i,
  output logic             txd_o,
  output logic             thre_o,
  output logic             temt_o
);
  logic      tick;
  line_ctl_t ctl;

  assign ctl = line_ctl_t'(lcr_i);

  tx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .tick_o (tick)
  );

  tx_frame #(.OSR(OSR)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctl_i     (ctl),
    .cts_i     (cts_i),
    .txd_o     (txd_o),
    .thre_o    (thre_o),
    .temt_o    (temt_o)
  );

  // R9
  temt_thre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temt_o |-> thre_o && txd_o == !lcr_i[6]);
endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [6:0]  lcr_i = '0;
  logic [15:0] div_i = 16'd1;
  logic        cts_i = 1'b1;
  logic        txd_o, thre_o, temt_o;
  int          errors = 0;
  int          checks = 0;

  always #10 clk_i = ~clk_i;

  serial_frame_tx u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .lcr_i, .div_i, .cts_i,
    .txd_o, .thre_o, .temt_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(thre_o == 1'b0, "R8 thre low after write", thre_o, 0);
  endtask

  // waits for start edge then checks the whole frame against lcr_i/data
  task automatic capture(input logic [7:0] d, input int dv);
    int nb, L, wait_n;
    logic [7:0] got, expd;
    logic pexp;
    bit found;
    nb = 5 + int'(lcr_i[1:0]);
    expd = d & 8'((1 << nb) - 1);
    pexp = lcr_i[5] ? ~lcr_i[4] : (lcr_i[4] ? ^expd : ~^expd);
    L = !lcr_i[2] ? 16 : (nb == 5 ? 24 : 32);
    found = 0;
    for (int i = 0; i < 4000 && !found; i++) begin
      @(negedge clk_i);
      if (txd_o == 1'b0) found = 1;
    end
    chk(found, "R1 start edge seen", found, 1);
    if (!found) return;
    chk(thre_o == 1'b1, "R8 thre high after load", thre_o, 1);
    repeat (8 * dv - 1) @(negedge clk_i);
    chk(txd_o == 1'b0, "R1 start bit level", txd_o, 0);
    got = '0;
    for (int b = 0; b < nb; b++) begin
      repeat (16 * dv) @(negedge clk_i);
      got[b] = txd_o;
    end
    chk(got == expd, "R1/R6 data bits", got, expd);
    if (lcr_i[3]) begin
      repeat (16 * dv) @(negedge clk_i);
      chk(txd_o == pexp, lcr_i[5] ? "R3 sticky parity" : "R2 parity bit", txd_o, pexp);
    end
    repeat (16 * dv) @(negedge clk_i);
    chk(txd_o == 1'b1, "R4 stop level", txd_o, 1);
    wait_n = (L - 10) * dv;
    repeat (wait_n) @(negedge clk_i);
    chk(temt_o == 1'b0 && txd_o == 1'b1, "R4/R9 still in stop", {temt_o, txd_o}, 1);
    repeat (4 * dv) @(negedge clk_i);
    chk(temt_o == 1'b1 && txd_o == 1'b1, "R4/R9 empty after stop", {temt_o, txd_o}, 3);
  endtask

  initial begin
    #(20 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(txd_o && thre_o && temt_o, "R10 reset state", {txd_o, thre_o, temt_o}, 7);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // full format sweep at div=1
    for (int f = 0; f < 64; f++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] d;
        d = 8'((f * 37 + k * 91 + 8'h5a) & 8'hff);
        lcr_i = 7'(f);
        write_byte(d);
        capture(d, 1);
      end
    end

    // bit time scales with divisor
    div_i = 16'd3;
    for (int f = 0; f < 4; f++) begin
      lcr_i = 7'(f * 13 + 3) & 7'h3f;
      write_byte(8'hc6 ^ 8'(f));
      capture(8'hc6 ^ 8'(f), 3);
    end

    // zero divisor stalls
    div_i = 16'd0; lcr_i = 7'h03;
    write_byte(8'h81);
    begin
      bit idle_ok = 1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk_i);
        if (!txd_o || thre_o) idle_ok = 0;
      end
      chk(idle_ok, "R6 zero divisor holds idle", idle_ok, 1);
    end
    div_i = 16'd1;
    capture(8'h81, 1);

    // clear-to-send gating
    cts_i = 1'b0; lcr_i = 7'h0f;
    write_byte(8'h3e);
    begin
      bit idle_ok = 1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk_i);
        if (!txd_o || thre_o || temt_o) idle_ok = 0;
      end
      chk(idle_ok, "R7 cts low blocks start", idle_ok, 1);
    end
    cts_i = 1'b1;
    capture(8'h3e, 1);

    // break override, idle and mid-frame
    lcr_i = 7'h43;
    repeat (3) @(negedge clk_i);
    chk(txd_o == 1'b0, "R5 break while idle", txd_o, 0);
    write_byte(8'hff);
    begin
      bit brk_ok = 1;
      for (int i = 0; i < 120; i++) begin
        @(negedge clk_i);
        if (txd_o) brk_ok = 0;
      end
      chk(brk_ok, "R5 break holds line low", brk_ok, 1);
    end
    lcr_i = 7'h03;
    for (int i = 0; i < 400 && !temt_o; i++) @(negedge clk_i);
    chk(temt_o && txd_o, "R9 drained after break", {temt_o, txd_o}, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule